// File: doc/BRIEF.md
# Sliding Window Amplitude Detector

This block watches a stream of signed input samples and keeps a running sum of the magnitudes of the most recent N accepted samples. The sum is divided by N, using a right shift, to give the average amplitude over the window. That average is compared with a programmable threshold. When the average rises above the threshold, a protection trigger is raised. The trigger is meant to catch abnormally large input, for example the garbage that appears at a converter input after a link or interface fault. Downstream logic can then act on it.

The window length is chosen at run time from three power-of-two sizes. When the choice changes, the block discards everything it holds and keeps the trigger quiet until the new window has filled. Only samples marked valid enter the window.

Top module: `swad_detector`

## Requirements
- R1: The window select `win_sel_i` picks the window length: code 2'b00 selects 32 samples, 2'b01 selects 64 and 2'b10 selects 128.
- R2: The reserved select code 2'b11 behaves exactly like 2'b10, a window of 128 samples.
- R3: The window sum is the sum of the magnitudes of the last N accepted samples. The magnitude of a two's-complement sample is its absolute value, and the most negative code (-32768 at 16 bits) has magnitude 32768.
- R4: With the window full, `trig_o` is high exactly when floor(sum / N) is strictly greater than `thresh_i`, read as unsigned. An average equal to the threshold does not trigger.
- R5: `trig_o` reflects the window and threshold as they stood one clock earlier. A sample accepted at edge k first affects `trig_o` after edge k+1, and a threshold presented at edge k affects `trig_o` after edge k.
- R6: When `sample_valid_i` is low, `sample_i` has no effect on the window contents.
- R7: A change of `win_sel_i` empties the window and forces `trig_o` low from that edge on. A sample presented with valid high in the same cycle as the change is discarded, and `trig_o` stays low until N new samples have been accepted.
- R8: The sum cannot overflow. A 128-sample window of most-negative samples gives an average of exactly 32768.
- R9: After reset `trig_o` is low and the window is empty.
- R10: A sample leaves the window after exactly N later samples have been accepted, so its contribution to the average vanishes at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sample_valid_i | input | 1 | Qualifies `sample_i` in this cycle |
| sample_i | input | 16 | Signed two's-complement input sample |
| win_sel_i | input | 2 | Window length select (00: 32, 01: 64, 10 and 11: 128) |
| thresh_i | input | 16 | Unsigned average-amplitude threshold |
| trig_o | output | 1 | Protection trigger, registered |

## Verification
A sample accepted at a clock edge reaches the window sum at that edge, and the trigger register captures the comparison at the next edge. The bench therefore waits one idle cycle after each push before it samples `trig_o` on the falling edge. It also checks once directly after a push, to confirm that the new sample has not yet shown up. A threshold or select change is visible at the first falling edge after the rising edge that captures it, so those checks wait exactly one cycle. Tests that fill a window check the not-yet-full state after N-1 samples and the triggered state after sample N.

// File: rtl/swad_pkg.sv
package swad_pkg;

  localparam int unsigned SEL_W = 2;

  // Maps a window select code to log2 of the window length; codes at or
  // beyond the last size saturate to the largest window.
  function automatic int unsigned win_log2(input logic [SEL_W-1:0] sel,
                                           input int unsigned     min_log2,
                                           input int unsigned     num_sizes);
    int unsigned code;
    code = {30'd0, sel};
    if (code >= num_sizes - 1) return min_log2 + num_sizes - 1;
    return min_log2 + code;
  endfunction

endpackage

// File: rtl/swad_rst_sync.sv
module swad_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_no = sync_q;

endmodule

// File: rtl/swad_history.sv
module swad_history #(
  parameter int unsigned MAG_W     = 16,
  parameter int unsigned MAX_DEPTH = 128,
  parameter int unsigned LOG2_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [MAG_W-1:0]  mag_i,
  input  logic [LOG2_W-1:0] win_log2_i,
  output logic [MAG_W-1:0]  oldest_o,
  output logic              full_o
);

  localparam int unsigned PTR_W = $clog2(MAX_DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  logic [MAG_W-1:0] mem_q [MAX_DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d;
  logic [CNT_W-1:0] fill_q, fill_d;
  logic [CNT_W-1:0] win_len;
  logic [PTR_W-1:0] rd_idx;
  logic             wr_en;

  always_comb begin
    win_len  = CNT_W'(1) << win_log2_i;
    full_o   = (fill_q == win_len);
    // Entry written N pushes ago; for the largest window this wraps to wr_q.
    rd_idx   = wr_q - win_len[PTR_W-1:0];
    oldest_o = full_o ? mem_q[rd_idx] : '0;
    wr_en    = push_i && !clear_i;
  end

  always_comb begin
    wr_d   = wr_q;
    fill_d = fill_q;
    if (clear_i) begin
      wr_d   = '0;
      fill_d = '0;
    end else if (push_i) begin
      wr_d   = wr_q + PTR_W'(1);
      fill_d = full_o ? fill_q : fill_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      fill_q <= '0;
    end else begin
      wr_q   <= wr_d;
      fill_q <= fill_d;
    end
  end

  // Storage carries no reset: stale entries are masked by the fill count.
  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_q] <= mag_i;
  end

  // R7
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> (fill_q <= win_len));

endmodule

// File: rtl/swad_accum.sv
module swad_accum #(
  parameter int unsigned MAG_W = 16,
  parameter int unsigned ACC_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic [MAG_W-1:0] mag_in_i,
  input  logic [MAG_W-1:0] mag_out_i,
  output logic [ACC_W-1:0] sum_o
);

  logic [ACC_W-1:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (clear_i)     sum_d = '0;
    else if (push_i) sum_d = sum_q + ACC_W'(mag_in_i) - ACC_W'(mag_out_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_d;
  end

  assign sum_o = sum_q;

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !clear_i) |=> $stable(sum_o));

endmodule

// File: rtl/swad_compare.sv
module swad_compare #(
  parameter int unsigned MAG_W    = 16,
  parameter int unsigned ACC_W    = 23,
  parameter int unsigned THRESH_W = 16,
  parameter int unsigned LOG2_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                full_i,
  input  logic [ACC_W-1:0]    sum_i,
  input  logic [LOG2_W-1:0]   win_log2_i,
  input  logic [THRESH_W-1:0] thresh_i,
  output logic                trig_o
);

  localparam logic [ACC_W-1:0] MAG_PEAK = ACC_W'(1) << (MAG_W - 1);

  logic [ACC_W-1:0] avg;
  logic             trig_d, trig_q;

  always_comb begin
    avg    = sum_i >> win_log2_i;
    trig_d = !clear_i && full_i && (avg > ACC_W'(thresh_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_d;
  end

  assign trig_o = trig_q;

  // R8
  avg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> (avg <= MAG_PEAK));

  // R4
  trig_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(full_i));

endmodule

// File: rtl/swad_detector.sv
module swad_detector #(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned THRESH_W  = 16,
  parameter int unsigned MIN_LOG2  = 5,
  parameter int unsigned NUM_SIZES = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sample_valid_i,
  input  logic [SAMPLE_W-1:0]          sample_i,
  input  logic [swad_pkg::SEL_W-1:0]   win_sel_i,
  input  logic [THRESH_W-1:0]          thresh_i,
  output logic                         trig_o
);

  localparam int unsigned MAX_LOG2  = MIN_LOG2 + NUM_SIZES - 1;
  localparam int unsigned MAX_DEPTH = 1 << MAX_LOG2;
  localparam int unsigned LOG2_W    = $clog2(MAX_LOG2 + 1);
  localparam int unsigned MAG_W     = SAMPLE_W;
  localparam int unsigned ACC_W     = MAG_W + MAX_LOG2;

  logic                       rst_n;
  logic [swad_pkg::SEL_W-1:0] sel_q;
  logic                       win_chg, push;
  logic [LOG2_W-1:0]          win_log2;
  logic [MAG_W-1:0]           mag, oldest;
  logic                       full;
  logic [ACC_W-1:0]           sum;

  swad_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  always_comb begin
    win_chg  = (win_sel_i != sel_q);
    push     = sample_valid_i && !win_chg;
    win_log2 = LOG2_W'(swad_pkg::win_log2(win_sel_i, MIN_LOG2, NUM_SIZES));
    // Two's-complement absolute value; the most negative code maps to 2^(W-1).
    mag      = sample_i[SAMPLE_W-1] ? (~sample_i + MAG_W'(1)) : sample_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= win_sel_i;
  end

  swad_history #(
    .MAG_W     (MAG_W),
    .MAX_DEPTH (MAX_DEPTH),
    .LOG2_W    (LOG2_W)
  ) u_history (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .clear_i    (win_chg),
    .push_i     (push),
    .mag_i      (mag),
    .win_log2_i (win_log2),
    .oldest_o   (oldest),
    .full_o     (full)
  );

  swad_accum #(
    .MAG_W (MAG_W),
    .ACC_W (ACC_W)
  ) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .clear_i   (win_chg),
    .push_i    (push),
    .mag_in_i  (mag),
    .mag_out_i (oldest),
    .sum_o     (sum)
  );

  swad_compare #(
    .MAG_W    (MAG_W),
    .ACC_W    (ACC_W),
    .THRESH_W (THRESH_W),
    .LOG2_W   (LOG2_W)
  ) u_compare (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .clear_i    (win_chg),
    .full_i     (full),
    .sum_i      (sum),
    .win_log2_i (win_log2),
    .thresh_i   (thresh_i),
    .trig_o     (trig_o)
  );

  // R7
  sel_change_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    win_chg |=> !trig_o);

endmodule

// File: tb/swad_detector_tb.sv
module swad_detector_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        sample_valid_i;
  logic [15:0] sample_i;
  logic [1:0]  win_sel_i;
  logic [15:0] thresh_i;
  logic        trig_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #10 clk_i = ~clk_i;

  swad_detector u_dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sample_valid_i (sample_valid_i),
    .sample_i       (sample_i),
    .win_sel_i      (win_sel_i),
    .thresh_i       (thresh_i),
    .trig_o         (trig_o)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
        summary();
        $finish;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: trig_o actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic push(input int v);
    sample_valid_i = 1'b1;
    sample_i       = 16'(v);
    @(negedge clk_i);
    sample_valid_i = 1'b0;
  endtask

  task automatic push_n(input int n, input int v);
    for (int i = 0; i < n; i++) push(v);
  endtask

  task automatic set_sel(input logic [1:0] s);
    win_sel_i = s;
    @(negedge clk_i);
  endtask

  task automatic set_thresh(input int t);
    thresh_i = 16'(t);
    @(negedge clk_i);
  endtask

  // R9: quiet after reset
  task automatic t_reset();
    rst_ni = 1'b0; sample_valid_i = 1'b0; sample_i = '0;
    win_sel_i = 2'b00; thresh_i = '0;
    idle(5);
    rst_ni = 1'b1;
    idle(4);
    check("R9 reset", trig_o, 1'b0);
    push_n(31, 5000);
    idle(1);
    check("R9 empty after reset", trig_o, 1'b0);
    set_sel(2'b01);
  endtask

  // R1, R4, R5: 32-sample window
  task automatic t_win32();
    set_sel(2'b00);
    set_thresh(100);
    push_n(31, 200);
    idle(1);
    check("R1 window32 not full at 31", trig_o, 1'b0);
    push(200);
    check("R5 latency one cycle", trig_o, 1'b0);
    idle(1);
    check("R1 window32 full at 32", trig_o, 1'b1);
    set_thresh(200);
    check("R4 equal does not trigger", trig_o, 1'b0);
    set_thresh(199);
    check("R4 above triggers", trig_o, 1'b1);
    set_thresh(200);
  endtask

  // R6: invalid samples are ignored
  task automatic t_ignore();
    sample_i = 16'h7fff;
    for (int i = 0; i < 10; i++) begin
      sample_valid_i = 1'b0;
      @(negedge clk_i);
    end
    check("R6 invalid data ignored", trig_o, 1'b0);
    push(232);
    idle(1);
    check("R6 window intact after invalid data", trig_o, 1'b1);
  endtask

  // R10: the large sample leaves after 32 more
  task automatic t_slide();
    for (int i = 1; i <= 32; i++) begin
      push(200);
      idle(1);
      check("R10 sample leaves window", trig_o, (i < 32) ? 1'b1 : 1'b0);
    end
  endtask

  // R7: select change clears and discards sample in the same cycle
  task automatic t_selchg();
    set_thresh(99);
    win_sel_i = 2'b01;
    sample_valid_i = 1'b1;
    sample_i = 16'd30000;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
    check("R7 trigger low after change", trig_o, 1'b0);
    push_n(63, 100);
    idle(1);
    check("R7 low until refilled, change sample discarded", trig_o, 1'b0);
    push(100);
    idle(1);
    check("R1 window64 full at 64", trig_o, 1'b1);
  endtask

  // R3: magnitudes of negative samples
  task automatic t_neg();
    set_thresh(100);
    check("R4 equal threshold 64-window", trig_o, 1'b0);
    push_n(64, -101);
    idle(1);
    check("R3 negative magnitude", trig_o, 1'b1);
    set_thresh(101);
    check("R3 negative average exact", trig_o, 1'b0);
    for (int i = 0; i < 32; i++) begin
      push(102);
      push(-102);
    end
    idle(1);
    check("R3 mixed sign magnitudes", trig_o, 1'b1);
  endtask

  // R1: 128-sample window
  task automatic t_win128();
    set_sel(2'b10);
    set_thresh(999);
    push_n(127, 1000);
    idle(1);
    check("R1 window128 not full at 127", trig_o, 1'b0);
    push(1000);
    idle(1);
    check("R1 window128 full at 128", trig_o, 1'b1);
  endtask

  // R8: full-scale window does not overflow
  task automatic t_max();
    set_thresh(32767);
    push_n(128, -32768);
    idle(1);
    check("R8 full scale average above 32767", trig_o, 1'b1);
    set_thresh(32768);
    check("R8 full scale average equals 32768", trig_o, 1'b0);
  endtask

  // R2: reserved code acts as 128
  task automatic t_code11();
    set_sel(2'b11);
    check("R2 change to code 11 clears", trig_o, 1'b0);
    set_thresh(999);
    push_n(64, 1000);
    idle(1);
    check("R2 code 11 not full at 64", trig_o, 1'b0);
    push_n(63, 1000);
    idle(1);
    check("R2 code 11 not full at 127", trig_o, 1'b0);
    push(1000);
    idle(1);
    check("R2 code 11 full at 128", trig_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_win32();
    t_ignore();
    t_slide();
    t_selchg();
    t_neg();
    t_win128();
    t_max();
    t_code11();
    idle(2);
    summary();
    $finish;
  end

endmodule